// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block holds four breakpoint slots for a processor core's debug logic. Each slot has an address register plus a 2-bit kind field and an enable bit in a shared control register. On every cycle where the core presents an instruction pointer for checking, the unit compares that pointer against every execute-kind slot. It also takes per-slot hit flags from a separate data-access monitor for the write and read/write kinds. The outcome updates the hit bits of a status register and may raise a debug exception request.

A slot that matches always appears in the hit vector, even when it is disabled. The status register is only written back when an enabled slot hit, or when the core asks for a forced update. The exception request is a one-cycle pulse. It carries the full hit vector with it.

Software reaches the registers through an indexed port with a registered read. Slots 0 to 3 sit at indices 0 to 3, control at index 4 and status at index 5. Some bits of the control and status registers are fixed at one and read back as one whatever is written to them.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, address registers read 0, control reads 0x00000400, status reads 0xFFFF0FF0, and `exc_req` and `exc_hits` are 0.
- R2: A write with `reg_we` high stores `reg_wdata` at `reg_idx` (0..3 address, 4 control, 5 status). `reg_rdata` shows the indexed register one cycle after the index is applied. Indices 6 and 7 read 0. Control bit 10 and status bits 31:16 and 11:4 always read 1.
- R3: Control bits 3:0 are the enables of slots 0..3. The kind of slot i is in control bits [17+2i:16+2i]. Kind 0 (execute) matches when `eval_en` is high and the slot address equals `ip`.
- R4: Kind 1 (write) and kind 3 (read or write) match when `eval_en` and `wp_hit[i]` are high, whatever the slot address.
- R5: Kind 2 never matches, even when its address equals `ip` or its `wp_hit` bit is high.
- R6: When the status register is written back, bits 3:0 are replaced by the match vector of all four slots, disabled ones included. The other bits are kept.
- R7: Write-back happens only in an `eval_en` cycle where an enabled slot matched or `force_upd` is high. Otherwise an evaluation leaves the status unchanged.
- R8: `exc_req` is high for exactly the one cycle after an `eval_en` cycle with an enabled match, with `exc_hits` equal to the match vector. `force_upd` alone raises no request, and `exc_hits` is 0 whenever `exc_req` is low.
- R9: If a write-back and a software write to status happen in the same cycle, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| eval_en | input | 1 | Evaluate breakpoints this cycle |
| ip | input | 32 | Current instruction pointer |
| wp_hit | input | 4 | Per-slot data watchpoint hit flags |
| force_upd | input | 1 | Force status write-back this cycle |
| exc_req | output | 1 | Debug exception request pulse |
| exc_hits | output | 4 | Match vector with the request |

## Verification
The assertions check on every cycle that:
- a request follows only an evaluation cycle;
- `exc_hits` is zero without a request;
- the status hit bits agree with the request's vector;
- status is stable when neither an evaluation nor a write occurs;
- a kind-2 slot never shows in a request.

Some behaviour can only be shown by the bench's scenarios:
- which slots match for a given pointer and flag pattern;
- that a disabled match lands in status only under a forced update or beside an enabled hit;
- the fixed-one read-back values;
- the priority of write-back over a same-cycle software write.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  typedef enum logic [1:0] {
    BK_EXEC = 2'd0,
    BK_WR   = 2'd1,
    BK_IO   = 2'd2,
    BK_RW   = 2'd3
  } bk_kind_e;

  localparam int KIND_LSB = 16;
  localparam logic [31:0] CTL_FIX_DEF  = 32'h0000_0400;
  localparam logic [31:0] STAT_FIX_DEF = 32'hFFFF_0FF0;
endpackage

// File: rtl/dbg_bkpt_match.sv
module dbg_bkpt_match
  import dbg_bkpt_pkg::*;
#(
  parameter int W     = 32,
  parameter int NSLOT = 4
) (
  input  logic [W*NSLOT-1:0] addr_flat,
  input  logic [2*NSLOT-1:0] kinds,
  input  logic [W-1:0]       ip,
  input  logic [NSLOT-1:0]   wp_hit,
  input  logic               eval_en,
  output logic [NSLOT-1:0]   match
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    bk_kind_e kind;
    logic     ip_eq;
    assign kind  = bk_kind_e'(kinds[2*i +: 2]);
    assign ip_eq = (addr_flat[W*i +: W] == ip);
    always_comb begin
      unique case (kind)
        BK_EXEC:      match[i] = eval_en & ip_eq;
        BK_WR, BK_RW: match[i] = eval_en & wp_hit[i];
        default:      match[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs #(
  parameter int          W        = 32,
  parameter int          NSLOT    = 4,
  parameter int          IDX_W    = 3,
  parameter logic [W-1:0] CTL_FIX  = '0,
  parameter logic [W-1:0] STAT_FIX = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [W-1:0]       wdata,
  output logic [W-1:0]       rdata,
  input  logic               commit,
  input  logic [NSLOT-1:0]   hits,
  output logic [W*NSLOT-1:0] addr_flat,
  output logic [W-1:0]       ctl,
  output logic [W-1:0]       stat
);
  localparam logic [IDX_W-1:0] CTL_IDX  = IDX_W'(NSLOT);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NSLOT + 1);

  logic [W-1:0] rd_mux;

  for (genvar i = 0; i < NSLOT; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        addr_flat[W*i +: W] <= '0;
      else if (we && idx == IDX_W'(i))
        addr_flat[W*i +: W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctl <= CTL_FIX;
    else if (we && idx == CTL_IDX)
      ctl <= wdata | CTL_FIX;
  end

  // write-back from evaluation has priority over software (R9)
  always_ff @(posedge clk) begin
    if (rst)
      stat <= STAT_FIX;
    else if (commit)
      stat <= {stat[W-1:NSLOT], hits} | STAT_FIX;
    else if (we && idx == STAT_IDX)
      stat <= wdata | STAT_FIX;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (idx == IDX_W'(i)) rd_mux = addr_flat[W*i +: W];
    if (idx == CTL_IDX)  rd_mux = ctl;
    if (idx == STAT_IDX) rd_mux = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NSLOT    = 4,
  parameter logic [W-1:0] CTL_FIX  = CTL_FIX_DEF,
  parameter logic [W-1:0] STAT_FIX = STAT_FIX_DEF,
  localparam int         IDX_W    = $clog2(NSLOT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             eval_en,
  input  logic [W-1:0]     ip,
  input  logic [NSLOT-1:0] wp_hit,
  input  logic             force_upd,
  output logic             exc_req,
  output logic [NSLOT-1:0] exc_hits
);
  logic [W*NSLOT-1:0] addr_flat;
  logic [W-1:0]       ctl_q;
  logic [W-1:0]       stat_q;
  logic [NSLOT-1:0]   match_w;
  logic [NSLOT-1:0]   en_w;
  logic [2*NSLOT-1:0] kind_w;
  logic               hit_en;
  logic               commit;
  logic               unused_bits;

  assign en_w   = ctl_q[NSLOT-1:0];
  assign kind_w = ctl_q[KIND_LSB +: 2*NSLOT];
  assign unused_bits = ^{ctl_q, stat_q};

  dbg_bkpt_regs #(
    .W(W), .NSLOT(NSLOT), .IDX_W(IDX_W),
    .CTL_FIX(CTL_FIX), .STAT_FIX(STAT_FIX)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .commit(commit), .hits(match_w),
    .addr_flat(addr_flat), .ctl(ctl_q), .stat(stat_q)
  );

  dbg_bkpt_match #(.W(W), .NSLOT(NSLOT)) u_match (
    .addr_flat(addr_flat), .kinds(kind_w), .ip(ip), .wp_hit(wp_hit),
    .eval_en(eval_en), .match(match_w)
  );

  assign hit_en = |(match_w & en_w);
  assign commit = eval_en & (hit_en | force_upd);

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req  <= 1'b0;
      exc_hits <= '0;
    end else begin
      exc_req  <= hit_en;
      exc_hits <= hit_en ? match_w : '0;
    end
  end
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
  parameter int W     = 32,
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             eval_en,
  input logic             reg_we,
  input logic             exc_req,
  input logic [NSLOT-1:0] exc_hits,
  input logic [W-1:0]     ctl_q,
  input logic [W-1:0]     stat_q
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !eval_en |=> !exc_req);                                         // R8
  AST_HITS_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> exc_hits == '0);                                   // R8
  AST_REQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> stat_q[NSLOT-1:0] == exc_hits);                     // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!eval_en && !reg_we) |=> $stable(stat_q));                     // R7
  AST_AFTER_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !exc_req);                                       // R1

  for (genvar i = 0; i < NSLOT; i++) begin : g_io
    AST_IO_KIND_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      (exc_req && $past(ctl_q[16+2*i +: 2]) == 2'd2) |-> !exc_hits[i]); // R5
  end
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk #(.W(W), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .eval_en(eval_en), .reg_we(reg_we),
  .exc_req(exc_req), .exc_hits(exc_hits), .ctl_q(ctl_q), .stat_q(stat_q)
);

// File: tb/sim_dbg_bkpt_unit.sv
module sim_dbg_bkpt_unit;
  localparam int W = 32, NSLOT = 4, IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [IDX_W-1:0] reg_idx = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic eval_en = 1'b0;
  logic [W-1:0] ip = '0;
  logic [NSLOT-1:0] wp_hit = '0;
  logic force_upd = 1'b0;
  logic exc_req;
  logic [NSLOT-1:0] exc_hits;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic       req;
    logic [3:0] hits;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  dbg_bkpt_unit u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eval_en(eval_en),
    .ip(ip), .wp_hit(wp_hit), .force_upd(force_upd),
    .exc_req(exc_req), .exc_hits(exc_hits)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares request outputs against the scoreboard queue
  always @(posedge clk) begin
    logic pend;
    exp_t e;
    pend = eval_en;
    #2;
    if (!rst) begin
      if (pend) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 scoreboard empty act=%b exp=item", exc_req);
        end else begin
          e = q.pop_front();
          check({e.tag, " req"}, W'(exc_req), W'(e.req));
          check({e.tag, " hits"}, W'(exc_hits), W'(e.hits));
        end
      end else if (exc_req !== 1'b0 || exc_hits !== 4'b0) begin
        total++; bad++;
        $display("FAIL R8 idle cycle request act=%b/%b exp=0/0", exc_req, exc_hits);
      end
    end
  end

  task automatic do_eval(input logic [W-1:0] ip_v, input logic [3:0] wp, input logic frc,
                         input logic wr_stat, input logic [W-1:0] wdat,
                         input logic exp_req, input logic [3:0] exp_hits, input string tag);
    exp_t e;
    @(negedge clk);
    ip = ip_v; wp_hit = wp; force_upd = frc; eval_en = 1'b1;
    reg_we = wr_stat; reg_idx = 3'd5; reg_wdata = wdat;
    e.req = exp_req; e.hits = exp_hits; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    eval_en = 1'b0; reg_we = 1'b0; force_upd = 1'b0; wp_hit = '0;
  endtask

  task automatic write_reg(input logic [IDX_W-1:0] idx, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [IDX_W-1:0] idx, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    reg_idx = idx;
    @(posedge clk);
    #2;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 exc_req after reset", W'(exc_req), '0);
    check("R1 exc_hits after reset", W'(exc_hits), '0);
    for (int i = 0; i < 4; i++) read_reg(IDX_W'(i), '0, "R1 address reset");
    read_reg(3'd4, 32'h0000_0400, "R1 control reset");
    read_reg(3'd5, 32'hFFFF_0FF0, "R1 status reset");

    // slot0 exec en, slot1 exec disabled, slot2 write en, slot3 io en
    write_reg(3'd0, 32'h0000_1000);
    write_reg(3'd1, 32'h0000_2000);
    write_reg(3'd4, 32'h0090_000D);
    read_reg(3'd1, 32'h0000_2000, "R2 address readback");
    read_reg(3'd4, 32'h0090_040D, "R2 control fixed bit");
    read_reg(3'd6, '0, "R2 unused index 6");
    read_reg(3'd7, '0, "R2 unused index 7");

    do_eval(32'h2000, 4'b0000, 1'b0, 1'b0, '0, 1'b0, 4'b0000, "R7 disabled match no commit");
    read_reg(3'd5, 32'hFFFF_0FF0, "R7 status unchanged");
    do_eval(32'h2000, 4'b0000, 1'b1, 1'b0, '0, 1'b0, 4'b0000, "R8 force gives no request");
    read_reg(3'd5, 32'hFFFF_0FF2, "R6 forced disabled hit in status");
    do_eval(32'h1000, 4'b0000, 1'b0, 1'b0, '0, 1'b1, 4'b0001, "R3 exec hit");
    read_reg(3'd5, 32'hFFFF_0FF1, "R6 status replaced");
    do_eval(32'h0000, 4'b1000, 1'b0, 1'b0, '0, 1'b0, 4'b0000, "R5 io kind no hit");
    do_eval(32'h1000, 4'b1000, 1'b0, 1'b0, '0, 1'b1, 4'b0001, "R5 io flag ignored");
    do_eval(32'h3000, 4'b0100, 1'b0, 1'b0, '0, 1'b1, 4'b0100, "R4 write kind hit");
    read_reg(3'd5, 32'hFFFF_0FF4, "R4 status write hit");
    do_eval(32'h5000, 4'b1000, 1'b0, 1'b0, '0, 1'b0, 4'b0000, "R7 no match no change");
    read_reg(3'd5, 32'hFFFF_0FF4, "R7 status kept");
    do_eval(32'h2000, 4'b0100, 1'b0, 1'b0, '0, 1'b1, 4'b0110, "R6 disabled match reported");
    read_reg(3'd5, 32'hFFFF_0FF6, "R6 status with disabled slot");
    do_eval(32'h1000, 4'b0000, 1'b0, 1'b1, '0, 1'b1, 4'b0001, "R9 commit with sw write");
    read_reg(3'd5, 32'hFFFF_0FF1, "R9 write-back wins");

    write_reg(3'd5, 32'h0000_0000);
    read_reg(3'd5, 32'hFFFF_0FF0, "R2 status fixed ones");
    write_reg(3'd5, 32'h0000_000F);
    read_reg(3'd5, 32'hFFFF_0FFF, "R2 status hit bits writable");

    // slot1 read/write kind enabled, address irrelevant
    write_reg(3'd4, 32'h000C_0002);
    read_reg(3'd4, 32'h000C_0402, "R2 control rewrite");
    do_eval(32'h9999, 4'b0010, 1'b0, 1'b0, '0, 1'b1, 4'b0010, "R4 read-write kind hit");
    read_reg(3'd5, 32'hFFFF_0FF2, "R4 status read-write hit");
    do_eval(32'h2000, 4'b0000, 1'b0, 1'b0, '0, 1'b0, 4'b0000, "R4 address ignored for data kind");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule